// File: doc/BRIEF.md
# Receive Special Character Detector

This block sits on the receive path of a UART, between the deserializer and the receive FIFO. Every received byte passes through it and is forwarded to the FIFO one clock later, unchanged. When detection is switched on, each arriving byte is compared against a programmable 8-bit match value. A hit does not drop the byte. It is still written to the FIFO, and a sticky status flag is raised in the same cycle as that FIFO write, for use by the interrupt logic.

Detection cannot be used while software (Xon/Xoff) flow control is active. The enable is honoured only when the 4-bit software flow control mode field is zero. If the enable is set while that field is nonzero, no comparison is made and a configuration error flag is raised. The status flag is cleared by a status-read strobe. A match that lands in the same cycle as the clear wins, and the flag stays set.

Top module: `rx_spchar_det`

## Requirements
- R1: After reset, `fifo_valid`, `fifo_data`, `spchar_flag` and `cfg_err` are all 0. An asserted reset also clears a flag that was set.
- R2: Each byte presented with `rx_valid` high appears on `fifo_data` with `fifo_valid` high exactly one clock later, unchanged, whether or not it matched. `fifo_valid` is low one clock after a cycle with `rx_valid` low.
- R3: After reset detection is off. With `det_en` low, a byte equal to `match_char` does not set `spchar_flag`.
- R4: With `det_en` high and `swfc_mode` equal to 4'b0000, a valid byte equal to `match_char` sets `spchar_flag` at the same clock edge on which that byte appears on `fifo_valid`/`fifo_data`.
- R5: The comparison is bit for bit. Bit 0 of `match_char` is compared with bit 0 (the LSB) of `rx_data`, through to bit 7. A byte that differs in any single bit, LSB or MSB, is not a match.
- R6: When `det_en` is high and `swfc_mode` is nonzero, no comparison is made. `cfg_err` is 1 one clock later. In every other case `cfg_err` is 0 one clock later.
- R7: `spchar_flag` stays set until a cycle with `stat_clr` high and no new match. It then reads 0 from the next clock on.
- R8: A match in the same cycle as `stat_clr` leaves `spchar_flag` set.
- R9: A cycle with `rx_valid` low makes no comparison, even if `rx_data` equals `match_char`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte strobe |
| det_en | input | 1 | Special character detection enable |
| swfc_mode | input | 4 | Software flow control mode field (must be zero for detection) |
| match_char | input | 8 | Programmable match value, bit 0 against the LSB |
| stat_clr | input | 1 | Status-read strobe that clears the flag |
| fifo_data | output | 8 | Byte forwarded to the receive FIFO |
| fifo_valid | output | 1 | Write strobe for the receive FIFO |
| spchar_flag | output | 1 | Sticky special-character status |
| cfg_err | output | 1 | Detection enabled while software flow control is active |

## Verification
Every result of this block is due one clock after the inputs that cause it: the forwarded byte and strobe, the flag set or clear, and the configuration error. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples 1 ns after it. Each table row's expected values therefore describe the outputs caused by that row alone. The flag's stickiness is tracked from row to row in the table, so the hold, the clear and the clear-versus-match collision are each checked at the edge where they take effect.

// File: rtl/rx_spchar_pkg.sv
package rx_spchar_pkg;
  // Bitwise equality, bit i of the match value against bit i of the byte.
  function automatic logic spchar_eq(input logic [7:0] a, input logic [7:0] b);
    logic diff;
    diff = 1'b0;
    for (int i = 0; i < 8; i++) diff = diff | (a[i] ^ b[i]);
    return !diff;
  endfunction

  // Detection is legal only when the software flow control field is zero.
  function automatic logic swfc_idle(input logic [3:0] mode);
    return (mode == 4'b0000);
  endfunction
endpackage

// File: rtl/spchar_cmp.sv
module spchar_cmp
  import rx_spchar_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FC_W   = 4
) (
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              det_en,
  input  logic [FC_W-1:0]   swfc_mode,
  input  logic [DATA_W-1:0] match_char,
  output logic              hit,
  output logic              illegal
);
  logic legal_en;
  always_comb begin
    illegal  = det_en && !swfc_idle(swfc_mode);
    legal_en = det_en && swfc_idle(swfc_mode);
    hit      = rx_valid && legal_en && spchar_eq(rx_data, match_char);
  end
endmodule

// File: rtl/spchar_pipe.sv
module spchar_pipe #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_data  <= in_data;
    end
  end

  // R2: forwarded unchanged one clock later
  a_r2_forward: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid && out_data == $past(in_data)));
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
endmodule

// File: rtl/spchar_flag.sv
module spchar_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set_ev) flag <= 1'b1;
    else if (clr_ev) flag <= 1'b0;
  end

  a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_ev) |=> flag);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !set_ev) |=> !flag);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && set_ev) |=> flag);
endmodule

// File: rtl/rx_spchar_det.sv
module rx_spchar_det #(
  parameter int DATA_W = 8,
  parameter int FC_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic              det_en,
  input  logic [FC_W-1:0]   swfc_mode,
  input  logic [DATA_W-1:0] match_char,
  input  logic              stat_clr,
  output logic [DATA_W-1:0] fifo_data,
  output logic              fifo_valid,
  output logic              spchar_flag,
  output logic              cfg_err
);
  logic hit;
  logic illegal;

  spchar_cmp #(.DATA_W(DATA_W), .FC_W(FC_W)) u_cmp (
    .rx_valid(rx_valid), .rx_data(rx_data), .det_en(det_en),
    .swfc_mode(swfc_mode), .match_char(match_char),
    .hit(hit), .illegal(illegal)
  );

  spchar_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_data(rx_data),
    .out_valid(fifo_valid), .out_data(fifo_data)
  );

  spchar_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_ev(hit), .clr_ev(stat_clr), .flag(spchar_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= illegal;
  end

  // R6: no comparison while software flow control is active
  a_r6_no_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !hit);
  a_r6_err: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && swfc_mode != '0) |=> cfg_err);
  // R3: disabled means no comparison
  a_r3_off: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |-> !hit);
  // R9: no comparison without a valid byte
  a_r9_novalid: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> !hit);
  // R4: flag rises only together with a FIFO write
  a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spchar_flag) |-> fifo_valid);
endmodule

// File: tb/rx_spchar_det_tb.sv
module rx_spchar_det_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_valid = 1'b0;
  logic       det_en = 1'b0;
  logic [3:0] swfc_mode = '0;
  logic [7:0] match_char = '0;
  logic       stat_clr = 1'b0;
  logic [7:0] fifo_data;
  logic       fifo_valid;
  logic       spchar_flag;
  logic       cfg_err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_spchar_det u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .det_en(det_en), .swfc_mode(swfc_mode), .match_char(match_char),
    .stat_clr(stat_clr), .fifo_data(fifo_data), .fifo_valid(fifo_valid),
    .spchar_flag(spchar_flag), .cfg_err(cfg_err)
  );

  // Row: valid, en, mode[3:0], data[7:0], match[7:0], clr, exp_flag, exp_err
  localparam int NV = 13;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'h0, 8'h3C, 8'h3C, 1'b0, 1'b0, 1'b0}, // R3 disabled
    {1'b1, 1'b1, 4'h0, 8'h3C, 8'h3C, 1'b0, 1'b1, 1'b0}, // R4 match
    {1'b1, 1'b1, 4'h0, 8'h55, 8'h3C, 1'b0, 1'b1, 1'b0}, // R7 hold
    {1'b0, 1'b1, 4'h0, 8'h3C, 8'h3C, 1'b1, 1'b0, 1'b0}, // R7 clear, R9
    {1'b1, 1'b1, 4'h0, 8'h3D, 8'h3C, 1'b0, 1'b0, 1'b0}, // R5 LSB differs
    {1'b1, 1'b1, 4'h0, 8'hBC, 8'h3C, 1'b0, 1'b0, 1'b0}, // R5 MSB differs
    {1'b1, 1'b1, 4'h0, 8'h81, 8'h81, 1'b0, 1'b1, 1'b0}, // R4 new value
    {1'b1, 1'b1, 4'h0, 8'h81, 8'h81, 1'b1, 1'b1, 1'b0}, // R8 set wins
    {1'b0, 1'b0, 4'h0, 8'h00, 8'h81, 1'b1, 1'b0, 1'b0}, // R7 clear
    {1'b1, 1'b1, 4'h2, 8'h81, 8'h81, 1'b0, 1'b0, 1'b1}, // R6 mode 2
    {1'b1, 1'b1, 4'h8, 8'h81, 8'h81, 1'b0, 1'b0, 1'b1}, // R6 mode 8
    {1'b1, 1'b0, 4'h8, 8'h81, 8'h81, 1'b0, 1'b0, 1'b0}, // R6 no err when off
    {1'b0, 1'b1, 4'h0, 8'h81, 8'h81, 1'b0, 1'b0, 1'b0}  // R9 no valid
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic en, input logic [3:0] m,
                      input logic [7:0] d, input logic [7:0] mc, input logic c);
    @(negedge clk);
    rx_valid = v; det_en = en; swfc_mode = m; rx_data = d; match_char = mc; stat_clr = c;
    @(posedge clk);
    #1;
  endtask

  // Independent restatement: count of differing bits must be zero.
  function automatic logic tb_match(input logic [7:0] a, input logic [7:0] b);
    return $countones(a ^ b) == 0;
  endfunction

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 fifo_valid", {7'd0, fifo_valid}, 8'd0);
    check("R1 fifo_data", fifo_data, 8'd0);
    check("R1 flag", {7'd0, spchar_flag}, 8'd0);
    check("R1 cfg_err", {7'd0, cfg_err}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [24:0] r;
      r = VEC[i];
      step(r[24], r[23], r[22:19], r[18:11], r[10:3], r[2]);
      check("R2 fifo_valid", {7'd0, fifo_valid}, {7'd0, r[24]});
      if (r[24]) check("R2 fifo_data", fifo_data, r[18:11]);
      check("R4/R7 flag", {7'd0, spchar_flag}, {7'd0, r[1]});
      check("R6 cfg_err", {7'd0, cfg_err}, {7'd0, r[0]});
    end

    // R5: every single-bit difference is rejected
    for (int b = 0; b < 8; b++) begin
      logic [7:0] d;
      d = 8'hA5 ^ (8'd1 << b);
      step(1'b1, 1'b1, 4'h0, d, 8'hA5, 1'b1);
      check("R5 single-bit diff", {7'd0, spchar_flag}, {7'd0, tb_match(d, 8'hA5)});
    end

    // R1: reset clears a set flag
    step(1'b1, 1'b1, 4'h0, 8'h7E, 8'h7E, 1'b0);
    check("R4 flag before reset", {7'd0, spchar_flag}, 8'd1);
    @(negedge clk);
    rst_n = 1'b0;
    rx_valid = 1'b0;
    #2;
    check("R1 flag under reset", {7'd0, spchar_flag}, 8'd0);
    check("R1 fifo_valid under reset", {7'd0, fifo_valid}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule